// File: doc/BRIEF.md
# Adaptive Cluster Fold Network

This block sits between the per-cluster stream-buffer banks and the compute clusters of a SIMD datapath. When the workload offers less data parallelism than there are clusters, some clusters are powered down. Their bank contents are still needed, so the network time-multiplexes the words of every bank onto the clusters that stay on. The data does not make a round trip through memory.

A transfer begins with a one-cycle start pulse that carries a fold mode. The network latches the mode and captures one word from each bank. Its gate enables switch at once. From the next cycle onward it delivers the captured words to the active clusters, one batch per cycle, and raises a done flag with the last batch. The all-off mode only gates every cluster and delivers nothing. Mode changes take effect only through a start that arrives while the network is idle, which matches the fine-grained power-gating decisions made every few hundred microseconds.

Top module: `clfold_net`

## Requirements
- R1: After reset, all cluster enables, valid bits, data outputs and the done flag are 0.
- R2: A start accepted while idle sets the enables in the next cycle according to mode_i: 2'b00 gives 4'b1111, 2'b01 gives 4'b0011, 2'b10 gives 4'b0001 and 2'b11 gives 4'b0000 (bit c is cluster c).
- R3: New enables appear one cycle before the first delivery that uses them. The enables stay unchanged while data is delivered, and a valid bit is never high on a cluster whose enable is low.
- R4: In mode 2'b00, cluster c receives bank c in the single delivery cycle, two cycles after the start is sampled.
- R5: In mode 2'b01, cluster 0 receives bank 0 and then bank 2, and cluster 1 receives bank 1 and then bank 3, in two consecutive cycles.
- R6: In mode 2'b10, cluster 0 receives banks 0, 1, 2 and 3 in that order, in four consecutive cycles.
- R7: A start in mode 2'b11 clears all enables and produces no valid bit and no done flag.
- R8: done_o is high for exactly one cycle, the cycle of the last delivery of a transfer.
- R9: While a transfer is in progress, start_i and mode_i are ignored. The running sequence and the enables are unchanged, and no extra transfer follows.
- R10: In every cycle where a cluster's valid bit is low, its data output is 0.
- R11: Bank words are captured in the cycle the start is sampled, so later changes on bank_data_i do not alter the words delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Fold mode, sampled with an accepted start |
| start_i | input | 1 | One-cycle request to reconfigure and transfer |
| bank_data_i | input | N_CL*DATA_W | One read word per bank, bank c at bits c*DATA_W upward |
| cl_data_o | output | N_CL*DATA_W | Word delivered to each cluster |
| cl_valid_o | output | N_CL | Per-cluster delivery strobe |
| cl_en_o | output | N_CL | Per-cluster enable / power-gate control, 1 = powered |
| done_o | output | 1 | Pulses with the last delivery of a transfer |

## Verification
The bench builds the network with N_CL = 4 and a 16-bit DATA_W. At this size every fold ratio appears: the unfolded mode, two clusters that each take two banks, one cluster that takes all four, and full shutdown. Each batch can be checked word by word against the bank it should come from. Because there are only four clusters, the bench can also cover the transitions between modes: enables rising from all-off, dropping to a single cluster, and staying put while a start and a new mode arrive in the middle of a four-cycle transfer.

// File: rtl/clfold_pkg.sv
package clfold_pkg;

  typedef enum logic [1:0] {
    FOLD_NONE    = 2'b00,
    FOLD_HALF    = 2'b01,
    FOLD_QUARTER = 2'b10,
    FOLD_DARK    = 2'b11
  } fold_mode_e;

  localparam int unsigned PHASE_W = 2;

  // log2 of the number of banks folded onto one active cluster
  function automatic logic [1:0] fold_shift(fold_mode_e m);
    case (m)
      FOLD_HALF:    fold_shift = 2'd1;
      FOLD_QUARTER: fold_shift = 2'd2;
      default:      fold_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/clfold_ctrl.sv
module clfold_ctrl
  import clfold_pkg::*;
#(
  parameter int unsigned N_CL = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  fold_mode_e         mode_i,
  output logic               busy_o,
  output logic               cap_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [1:0]         shift_o,
  output logic [N_CL-1:0]    en_o,
  output logic               done_o
);

  typedef enum logic {ST_IDLE, ST_XFER} state_e;

  state_e             state_q, state_d;
  fold_mode_e         cfg_q, cfg_d;
  logic [N_CL-1:0]    en_q, en_d;
  logic [PHASE_W-1:0] phase_q, phase_d;
  logic               done_q, done_d;
  logic               cap;
  logic [PHASE_W-1:0] last_phase;

  function automatic logic [N_CL-1:0] gate_mask(fold_mode_e m);
    logic [N_CL-1:0] msk;
    int unsigned     act;
    act = N_CL >> fold_shift(m);
    for (int c = 0; c < N_CL; c++) begin
      msk[c] = (m != FOLD_DARK) && (c < act);
    end
    return msk;
  endfunction

  assign last_phase = PHASE_W'((1 << fold_shift(cfg_q)) - 1);

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    en_d    = en_q;
    phase_d = phase_q;
    done_d  = 1'b0;
    cap     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap     = 1'b1;
          cfg_d   = mode_i;
          en_d    = gate_mask(mode_i);
          phase_d = '0;
          if (mode_i != FOLD_DARK) state_d = ST_XFER;
        end
      end
      ST_XFER: begin
        phase_d = phase_q + 1'b1;
        if (phase_q == last_phase) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= FOLD_DARK;
      en_q    <= '0;
      phase_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      en_q    <= en_d;
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign busy_o  = (state_q == ST_XFER);
  assign cap_o   = cap;
  assign phase_o = phase_q;
  assign shift_o = fold_shift(cfg_q);
  assign en_o    = en_q;
  assign done_o  = done_q;

  // R8: the done flag never lasts two cycles
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: configuration and gating frozen while a transfer runs
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(shift_o));
  a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(en_o));

endmodule

// File: rtl/clfold_route.sv
module clfold_route
  import clfold_pkg::*;
#(
  parameter int unsigned N_CL   = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic [DATA_W-1:0]  bank_i  [N_CL],
  input  logic               load_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [1:0]         shift_i,
  output logic [DATA_W-1:0]  data_o  [N_CL],
  output logic [N_CL-1:0]    valid_o
);

  logic [DATA_W-1:0] bank_q [N_CL];
  logic [DATA_W-1:0] data_q [N_CL];
  logic [DATA_W-1:0] data_d [N_CL];
  logic [N_CL-1:0]   valid_q, valid_d;

  always_comb begin
    int act;
    int src;
    act = int'(N_CL >> shift_i);
    for (int c = 0; c < N_CL; c++) begin
      src       = c + int'(phase_i) * act;
      data_d[c] = '0;
      valid_d[c] = 1'b0;
      if (load_i && (c < act) && (src < N_CL)) begin
        data_d[c]  = bank_q[src];
        valid_d[c] = 1'b1;
      end
    end
  end

  generate
    for (genvar g = 0; g < N_CL; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          bank_q[g] <= '0;
        end else if (cap_i) begin
          bank_q[g] <= bank_i[g];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_q[g] <= '0;
        end else begin
          data_q[g] <= data_d[g];
        end
      end

      assign data_o[g] = data_q[g];

      // R10: a lane without a delivery carries zero
      a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o[g] |-> (data_o[g] == '0));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/clfold_net.sv
module clfold_net
  import clfold_pkg::*;
#(
  parameter int unsigned N_CL   = 4,   // multiple of 4
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             mode_i,
  input  logic                   start_i,
  input  logic [N_CL*DATA_W-1:0] bank_data_i,
  output logic [N_CL*DATA_W-1:0] cl_data_o,
  output logic [N_CL-1:0]        cl_valid_o,
  output logic [N_CL-1:0]        cl_en_o,
  output logic                   done_o
);

  logic               rst_meta, srst_n;
  logic               busy, cap;
  logic [PHASE_W-1:0] phase;
  logic [1:0]         shift;
  logic [DATA_W-1:0]  bank_arr [N_CL];
  logic [DATA_W-1:0]  out_arr  [N_CL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      srst_n   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      srst_n   <= rst_meta;
    end
  end

  generate
    for (genvar g = 0; g < N_CL; g++) begin : g_pack
      assign bank_arr[g]                  = bank_data_i[g*DATA_W +: DATA_W];
      assign cl_data_o[g*DATA_W +: DATA_W] = out_arr[g];
    end
  endgenerate

  clfold_ctrl #(.N_CL(N_CL)) u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .start_i (start_i),
    .mode_i  (fold_mode_e'(mode_i)),
    .busy_o  (busy),
    .cap_o   (cap),
    .phase_o (phase),
    .shift_o (shift),
    .en_o    (cl_en_o),
    .done_o  (done_o)
  );

  clfold_route #(.N_CL(N_CL), .DATA_W(DATA_W)) u_route (
    .clk     (clk),
    .rst_n   (srst_n),
    .cap_i   (cap),
    .bank_i  (bank_arr),
    .load_i  (busy),
    .phase_i (phase),
    .shift_i (shift),
    .data_o  (out_arr),
    .valid_o (cl_valid_o)
  );

  // R3: deliveries only reach powered clusters
  a_r3_valid_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_valid_o & ~cl_en_o) == '0);

  // R3: gating settled at least one cycle before each delivery
  a_r3_en_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (|cl_valid_o) |-> $stable(cl_en_o));

  // R8: done always accompanies a delivery
  a_r8_done_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (|cl_valid_o));

endmodule

// File: tb/clfold_net_bench.sv
module clfold_net_bench;

  localparam int NC = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      mode;
  logic            start;
  logic [NC*DW-1:0] bank_data;
  logic [NC*DW-1:0] cl_data;
  logic [NC-1:0]   cl_valid, cl_en;
  logic            done;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] bk [NC];

  always #4 clk = ~clk;

  clfold_net #(.N_CL(NC), .DATA_W(DW)) u_clfold_net (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode),
    .start_i     (start),
    .bank_data_i (bank_data),
    .cl_data_o   (cl_data),
    .cl_valid_o  (cl_valid),
    .cl_en_o     (cl_en),
    .done_o      (done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] exp_mask(input logic [1:0] m);
    case (m)
      2'b00:   return 4'b1111;
      2'b01:   return 4'b0011;
      2'b10:   return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] lane(input int c);
    return cl_data[c*DW +: DW];
  endfunction

  task automatic load_banks(input logic [DW-1:0] seed);
    for (int c = 0; c < NC; c++) begin
      bk[c] = seed + DW'(c * 16'h0111);
      bank_data[c*DW +: DW] = bk[c];
    end
  endtask

  task automatic send_start(input logic [1:0] m);
    @(negedge clk);
    mode  = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bank_data = ~bank_data;   // R11: later bank changes must not matter
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; mode = 2'b00; bank_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 enables", 64'(cl_en), 64'h0);
    chk("R1 valid", 64'(cl_valid), 64'h0);
    chk("R1 data", 64'(cl_data), 64'h0);
    chk("R1 done", 64'(done), 64'h0);
  endtask

  task automatic test_fold(input logic [1:0] m, input string rq, input logic [DW-1:0] seed);
    logic [NC-1:0] msk;
    int act, steps;
    msk   = exp_mask(m);
    act   = $countones(msk);
    steps = NC / act;
    load_banks(seed);
    send_start(m);
    chk("R2 enables", 64'(cl_en), 64'(msk));
    chk("R3 no delivery in lead cycle", 64'(cl_valid), 64'h0);
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      chk("R3 valid on enabled", 64'(cl_valid), 64'(msk));
      chk("R3 enables held", 64'(cl_en), 64'(msk));
      for (int c = 0; c < NC; c++) begin
        if (msk[c]) chk({rq, " route and R11 capture"}, 64'(lane(c)), 64'(bk[c + k*act]));
        else        chk("R10 gated lane zero", 64'(lane(c)), 64'h0);
      end
      chk("R8 done timing", 64'(done), 64'(k == steps-1));
    end
    @(negedge clk);
    chk("R8 done drops", 64'(done), 64'h0);
    chk("R10 valid drops", 64'(cl_valid), 64'h0);
    chk("R10 data zero after", 64'(cl_data), 64'h0);
  endtask

  task automatic test_dark();
    send_start(2'b11);
    chk("R7 enables off", 64'(cl_en), 64'h0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R7 no valid", 64'(cl_valid), 64'h0);
      chk("R7 no done", 64'(done), 64'h0);
      chk("R7 enables stay off", 64'(cl_en), 64'h0);
    end
  endtask

  task automatic test_busy_ignore();
    load_banks(16'h5A00);
    send_start(2'b10);
    chk("R9 enables quarter", 64'(cl_en), 64'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 sequence kept", 64'(lane(0)), 64'(bk[k]));
      chk("R9 enables kept", 64'(cl_en), 64'h1);
      chk("R9 valid kept", 64'(cl_valid), 64'h1);
      if (k == 1) begin
        mode  = 2'b00;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 no extra transfer", 64'(cl_valid), 64'h0);
      chk("R9 no extra done", 64'(done), 64'h0);
      chk("R9 mode not applied", 64'(cl_en), 64'h1);
    end
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    test_fold(2'b00, "R4", 16'h1000);   // enables rise from all-off
    test_fold(2'b01, "R5", 16'h2200);
    test_fold(2'b10, "R6", 16'h3300);
    test_busy_ignore();
    test_dark();
    test_fold(2'b00, "R4", 16'h4400);   // re-enable after shutdown
    test_fold(2'b10, "R6", 16'h7700);   // drop from all four to one
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule